// File: doc/BRIEF.md
# Two-Wire Slave Register Port

This block is the bus-facing half of a small register-mapped peripheral that sits on an I2C bus as a slave. It takes the raw SCL and SDA levels and brings them into the system clock domain with two flip-flops. A counter filter then rejects short pulses. START and STOP conditions are decoded from the filtered levels. The block recognises a 7-bit slave address made of a fixed 5-bit prefix and two strap inputs. It then accepts a register address byte, followed by write data or by a repeated START that turns the transfer into a read. SDA is only ever pulled low, through an open-drain enable, to acknowledge bytes and to send read data.

The register side sees a register address, a write data byte qualified by a one-cycle write strobe, and a one-cycle read request. The read byte is returned combinationally for the presented address. A one-cycle pulse marks each STOP. A busy input lets the register side refuse writes. A ready input holds the block deaf until power-up initialisation has finished. After each data byte, read or written, the register address advances by one, so burst writes and streaming reads walk through consecutive registers.

Top module: `i2c_regport`

## Requirements
- R1: The identification byte is accepted only when bits 7..3 equal 01010 and bits 2..1 equal `strap_i[1:0]`, with bit 0 as the direction (1 = read, 0 = write). On a mismatch SDA stays released in the ninth clock. Every further byte is then left unacknowledged and causes no strobe, until the next START or STOP.
- R2: The slave acknowledges, by pulling SDA low during the ninth SCL clock, a matching identification byte, the register address byte that follows a write identification, and each accepted write data byte.
- R3: Each accepted write data byte (bytes are sent MSB first and sampled on SCL rising edges) gives a one-cycle `wr_stb_o`. During that pulse, `reg_addr_o` holds the target register and `wr_data_o` holds the byte. The register address advances by one after each strobe, wrapping from 255 to 0.
- R4: A read is: write identification, address byte, repeated START, then read identification. It raises `rd_req_o` for one cycle with `reg_addr_o` at the register to read. It then sends `rd_data_i` MSB first, and SDA changes only while SCL is low.
- R5: While the master acknowledges the eighth bit of each read byte, the slave requests and sends the next register (address + 1, wrapping). After a master NACK, no further request is made and SDA stays released until START or STOP.
- R6: A write data byte that completes while `busy_i` is high is not acknowledged and gives no strobe. The rest of that transfer is ignored, and the register contents stay unchanged.
- R7: Each STOP (SDA rising while SCL is high) seen while ready gives a one-cycle `stop_o` pulse.
- R8: A pulse on SCL or SDA shorter than `FILT_CYC` system clocks has no effect. A pulse lasting at least `FILT_CYC + 2` clocks is seen.
- R9: While `ready_i` is low, START and STOP are ignored, no byte is acknowledged, and the SDA enable is released one cycle later.
- R10: After reset, `sda_oe_o`, `wr_stb_o`, `rd_req_o` and `stop_o` are low and `reg_addr_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ready_i | input | 1 | High once power-up initialisation is complete |
| scl_i | input | 1 | Raw SCL bus level |
| sda_i | input | 1 | Raw SDA bus level |
| sda_oe_o | output | 1 | 1 = pull SDA low (open-drain enable) |
| strap_i | input | 2 | Address strap pins, slave address bits 1..0 |
| busy_i | input | 1 | Register side cannot take writes |
| rd_data_i | input | 8 | Read byte for `reg_addr_o`, valid while `rd_req_o` is high |
| reg_addr_o | output | REG_AW | Current register address |
| wr_data_o | output | 8 | Last written data byte |
| wr_stb_o | output | 1 | One-cycle write strobe |
| rd_req_o | output | 1 | One-cycle read request |
| stop_o | output | 1 | One-cycle pulse on STOP |

## Verification
Every bus edge reaches the byte engine `FILT_CYC + 4` system clocks after it happens on the pins. That delay covers two synchroniser stages, the filter count, the edge register and the state register. An ACK or read bit therefore appears about that long after the SCL fall, and a strobe or request about that long after the relevant SCL rise. The bench runs the bus with a quarter bit period of 20 clocks, which is several times that latency. It reads SDA in the middle of the SCL high phase and counts strobes, requests and STOP pulses with monitors on the falling clock edge. It compares the counts and the captured address and data only after each transfer's STOP has settled. The filter is checked with SDA pulses just below and well above the threshold on an idle bus.

// File: rtl/i2c_regport_pkg.sv
package i2c_regport_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ID,
        ST_ADDR,
        ST_WDATA,
        ST_ACK_WAIT,
        ST_ACK_HOLD,
        ST_TX,
        ST_MACK,
        ST_MWAIT,
        ST_IGNORE
    } rp_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_ev_t;

    localparam int BYTE_W   = 8;
    localparam int STRAP_W  = 2;
    localparam int PREFIX_W = 7 - STRAP_W;

endpackage

// File: rtl/i2c_rp_filt.sv
module i2c_rp_filt #(
    parameter int FILT_CYC = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic flt_o
);
    localparam int CW = $clog2(FILT_CYC + 1);

    typedef struct packed {
        logic [1:0]    sync;
        logic          lvl;
        logic [CW-1:0] cnt;
    } filt_s;

    filt_s q, n;

    always_comb begin
        n      = q;
        n.sync = {q.sync[0], raw_i};
        if (q.sync[1] == q.lvl) begin
            n.cnt = '0;
        end else if (q.cnt == CW'(FILT_CYC - 1)) begin
            n.lvl = q.sync[1];
            n.cnt = '0;
        end else begin
            n.cnt = q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{sync: 2'b11, lvl: 1'b1, cnt: '0};
        end else begin
            q <= n;
        end
    end

    assign flt_o = q.lvl;

endmodule

// File: rtl/i2c_rp_cond.sv
module i2c_rp_cond
    import i2c_regport_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    scl_f,
    input  logic    sda_f,
    output bus_ev_t ev_o
);
    typedef struct packed {
        logic scl;
        logic sda;
    } prev_s;

    prev_s q, n;

    always_comb begin
        n.scl      = scl_f;
        n.sda      = sda_f;
        ev_o.start = scl_f & q.scl & q.sda & ~sda_f;
        ev_o.stop  = scl_f & q.scl & ~q.sda & sda_f;
        ev_o.rise  = scl_f & ~q.scl;
        ev_o.fall  = ~scl_f & q.scl;
        ev_o.sda   = sda_f;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{scl: 1'b1, sda: 1'b1};
        end else begin
            q <= n;
        end
    end

endmodule

// File: rtl/i2c_rp_fsm.sv
module i2c_rp_fsm
    import i2c_regport_pkg::*;
#(
    parameter int                    REG_AW    = 8,
    parameter logic [PREFIX_W-1:0]   ID_PREFIX = 5'b01010
) (
    input  logic               clk,
    input  logic               rst_n,
    input  bus_ev_t            ev_i,
    input  logic               ready_i,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic               busy_i,
    input  logic [BYTE_W-1:0]  rd_data_i,
    output logic [REG_AW-1:0]  reg_addr_o,
    output logic [BYTE_W-1:0]  wr_data_o,
    output logic               wr_stb_o,
    output logic               rd_req_o,
    output logic               stop_o,
    output logic               sda_oe_o
);
    localparam int BC_W = $clog2(BYTE_W);
    localparam logic [BC_W-1:0] LAST_BIT = BC_W'(BYTE_W - 1);

    typedef struct packed {
        rp_state_e          st;
        rp_state_e          nxt;
        logic [BC_W-1:0]    bitc;
        logic [BYTE_W-1:0]  sh;
        logic [BYTE_W-1:0]  tx;
        logic               ack;
        logic [REG_AW-1:0]  addr;
        logic [BYTE_W-1:0]  wdat;
        logic               wstb;
        logic               rreq;
        logic               stp;
        logic               oe;
    } fsm_s;

    fsm_s q, n;
    logic [BYTE_W-1:0] byte_in;
    logic              id_hit;

    always_comb begin
        byte_in = {q.sh[BYTE_W-2:0], ev_i.sda};
        id_hit  = (byte_in[BYTE_W-1 -: PREFIX_W] == ID_PREFIX) &&
                  (byte_in[STRAP_W:1] == strap_i);

        n      = q;
        n.wstb = 1'b0;
        n.rreq = 1'b0;
        n.stp  = 1'b0;

        // address advances the cycle after a strobe or request is presented
        if (q.wstb || q.rreq) begin
            n.addr = q.addr + REG_AW'(1);
        end
        if (q.rreq) begin
            n.tx = rd_data_i;
        end

        if (!ready_i) begin
            n.st = ST_IDLE;
            n.oe = 1'b0;
        end else if (ev_i.start) begin
            n.st   = ST_ID;
            n.bitc = '0;
            n.oe   = 1'b0;
        end else if (ev_i.stop) begin
            n.st  = ST_IDLE;
            n.oe  = 1'b0;
            n.stp = 1'b1;
        end else begin
            unique case (q.st)
                ST_ID, ST_ADDR, ST_WDATA: begin
                    if (ev_i.rise) begin
                        n.sh   = byte_in;
                        n.bitc = q.bitc + BC_W'(1);
                        if (q.bitc == LAST_BIT) begin
                            n.bitc = '0;
                            n.st   = ST_ACK_WAIT;
                            if (q.st == ST_ID) begin
                                if (!id_hit) begin
                                    n.st = ST_IGNORE;
                                end else if (byte_in[0]) begin
                                    n.ack  = 1'b1;
                                    n.nxt  = ST_TX;
                                    n.rreq = 1'b1;
                                end else begin
                                    n.ack = 1'b1;
                                    n.nxt = ST_ADDR;
                                end
                            end else if (q.st == ST_ADDR) begin
                                n.addr = byte_in[REG_AW-1:0];
                                n.ack  = 1'b1;
                                n.nxt  = ST_WDATA;
                            end else if (busy_i) begin
                                n.ack = 1'b0;
                                n.nxt = ST_IGNORE;
                            end else begin
                                n.ack  = 1'b1;
                                n.nxt  = ST_WDATA;
                                n.wstb = 1'b1;
                                n.wdat = byte_in;
                            end
                        end
                    end
                end
                ST_ACK_WAIT: begin
                    if (ev_i.fall) begin
                        n.oe = q.ack;
                        n.st = ST_ACK_HOLD;
                    end
                end
                ST_ACK_HOLD: begin
                    if (ev_i.fall) begin
                        n.st   = q.nxt;
                        n.bitc = '0;
                        n.oe   = (q.nxt == ST_TX) ? ~q.tx[BYTE_W-1] : 1'b0;
                    end
                end
                ST_TX: begin
                    if (ev_i.fall) begin
                        if (q.bitc == LAST_BIT) begin
                            n.oe   = 1'b0;
                            n.bitc = '0;
                            n.st   = ST_MACK;
                        end else begin
                            n.tx   = {q.tx[BYTE_W-2:0], 1'b0};
                            n.oe   = ~q.tx[BYTE_W-2];
                            n.bitc = q.bitc + BC_W'(1);
                        end
                    end
                end
                ST_MACK: begin
                    if (ev_i.rise) begin
                        if (!ev_i.sda) begin
                            n.rreq = 1'b1;
                            n.st   = ST_MWAIT;
                        end else begin
                            n.st = ST_IGNORE;
                        end
                    end
                end
                ST_MWAIT: begin
                    if (ev_i.fall) begin
                        n.st   = ST_TX;
                        n.bitc = '0;
                        n.oe   = ~q.tx[BYTE_W-1];
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, nxt: ST_IDLE, default: '0};
        end else begin
            q <= n;
        end
    end

    assign reg_addr_o = q.addr;
    assign wr_data_o  = q.wdat;
    assign wr_stb_o   = q.wstb;
    assign rd_req_o   = q.rreq;
    assign stop_o     = q.stp;
    assign sda_oe_o   = q.oe;

endmodule

// File: rtl/i2c_regport.sv
module i2c_regport
    import i2c_regport_pkg::*;
#(
    parameter int                  FILT_CYC  = 5,
    parameter int                  REG_AW    = 8,
    parameter logic [PREFIX_W-1:0] ID_PREFIX = 5'b01010
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ready_i,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe_o,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic               busy_i,
    input  logic [BYTE_W-1:0]  rd_data_i,
    output logic [REG_AW-1:0]  reg_addr_o,
    output logic [BYTE_W-1:0]  wr_data_o,
    output logic               wr_stb_o,
    output logic               rd_req_o,
    output logic               stop_o
);
    localparam int N_LINES = 2;

    logic [N_LINES-1:0] raw_lines;
    logic [N_LINES-1:0] flt_lines;
    logic               scl_flt;
    logic               sda_flt;
    bus_ev_t            bus_ev;

    assign raw_lines = {scl_i, sda_i};

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        i2c_rp_filt #(.FILT_CYC(FILT_CYC)) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .raw_i (raw_lines[g]),
            .flt_o (flt_lines[g])
        );
    end

    assign scl_flt = flt_lines[1];
    assign sda_flt = flt_lines[0];

    i2c_rp_cond u_cond (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_f (scl_flt),
        .sda_f (sda_flt),
        .ev_o  (bus_ev)
    );

    i2c_rp_fsm #(
        .REG_AW    (REG_AW),
        .ID_PREFIX (ID_PREFIX)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_i       (bus_ev),
        .ready_i    (ready_i),
        .strap_i    (strap_i),
        .busy_i     (busy_i),
        .rd_data_i  (rd_data_i),
        .reg_addr_o (reg_addr_o),
        .wr_data_o  (wr_data_o),
        .wr_stb_o   (wr_stb_o),
        .rd_req_o   (rd_req_o),
        .stop_o     (stop_o),
        .sda_oe_o   (sda_oe_o)
    );

endmodule

// File: rtl/i2c_regport_chk.sv
module i2c_regport_chk (
    input logic clk,
    input logic rst_n,
    input logic ready_i,
    input logic busy_i,
    input logic scl_f,
    input logic sda_oe_o,
    input logic wr_stb_o,
    input logic rd_req_o,
    input logic stop_o
);
    a_r3_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_o |=> !wr_stb_o);

    a_r3_stb_not_with_req: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_stb_o && rd_req_o));

    a_r4_req_single: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |=> !rd_req_o);

    a_r4_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_oe_o) && $past(ready_i)) |-> !scl_f);

    a_r6_busy_no_stb: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_o |-> !$past(busy_i));

    a_r7_stop_single: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o |=> !stop_o);

    a_r9_unready_release: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_i |=> !sda_oe_o);

endmodule

bind i2c_regport i2c_regport_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ready_i  (ready_i),
    .busy_i   (busy_i),
    .scl_f    (scl_flt),
    .sda_oe_o (sda_oe_o),
    .wr_stb_o (wr_stb_o),
    .rd_req_o (rd_req_o),
    .stop_o   (stop_o)
);

// File: tb/sim_i2c_regport.sv
`timescale 1ns/1ps
module sim_i2c_regport;
    localparam int Q       = 20;
    localparam int N_VEC   = 4;
    localparam logic [7:0] ID_W = 8'h54;   // 01010 + strap 10 + write
    localparam logic [7:0] ID_R = 8'h55;
    // {register address, data}
    localparam logic [15:0] WVEC [N_VEC] = '{16'h05A5, 16'h0A3C, 16'h7F00, 16'hFF5E};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ready_i = 1'b0;
    logic       busy_i = 1'b0;
    logic       m_scl = 1'b1, m_sda = 1'b1, g_scl = 1'b0, g_sda = 1'b0;
    logic [1:0] strap_i = 2'b10;
    logic       sda_oe_o, wr_stb_o, rd_req_o, stop_o;
    logic [7:0] reg_addr_o, wr_data_o, rd_data_i;
    logic       scl_i, sda_i;
    logic [7:0] mem [256];

    int nchk = 0, nfail = 0;
    int wr_cnt = 0, rd_cnt = 0, stop_cnt = 0;
    logic [7:0] last_wa = 8'h00, last_wd = 8'h00;
    bit done = 1'b0;

    always #5 clk = ~clk;

    assign scl_i     = m_scl ^ g_scl;
    assign sda_i     = (m_sda ^ g_sda) & ~sda_oe_o;
    assign rd_data_i = mem[reg_addr_o];

    i2c_regport u0 (
        .clk(clk), .rst_n(rst_n), .ready_i(ready_i), .scl_i(scl_i), .sda_i(sda_i),
        .sda_oe_o(sda_oe_o), .strap_i(strap_i), .busy_i(busy_i), .rd_data_i(rd_data_i),
        .reg_addr_o(reg_addr_o), .wr_data_o(wr_data_o), .wr_stb_o(wr_stb_o),
        .rd_req_o(rd_req_o), .stop_o(stop_o)
    );

    // register-side model: unwritten register k reads k ^ 3C
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'h3C;
        end else if (wr_stb_o) begin
            mem[reg_addr_o] <= wr_data_o;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_stb_o) begin
                wr_cnt++;
                last_wa = reg_addr_o;
                last_wd = wr_data_o;
            end
            if (rd_req_o) rd_cnt++;
            if (stop_o)   stop_cnt++;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; m_scl = 1'b1; wq();
        m_sda = 1'b0; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic bus_rstart();
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b0; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b1; wq(); wq();
    endtask

    task automatic send_bit(input logic b);
        m_sda = b; wq();
        m_scl = 1'b1; wq(); wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic recv_bit(output logic b);
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        b = sda_i; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic send_byte(input logic [7:0] d, output logic acked);
        logic x;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        recv_bit(x);
        acked = ~x;
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] d);
        logic x;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(x);
            d[i] = x;
        end
        send_bit(nack);
    endtask

    task automatic set_addr(input logic [7:0] a, output logic [1:0] acks);
        logic k0, k1;
        bus_start();
        send_byte(ID_W, k0);
        send_byte(a, k1);
        acks = {k0, k1};
    endtask

    initial begin
        logic k0, k1, k2, k3;
        logic [1:0] ka;
        logic [7:0] d;
        int w0, r0, s0;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R10: reset values
        chk("R10 sda_oe", sda_oe_o, 0);
        chk("R10 wr_stb", wr_stb_o, 0);
        chk("R10 rd_req", rd_req_o, 0);
        chk("R10 stop", stop_o, 0);
        chk("R10 reg_addr", reg_addr_o, 0);

        // R9: not ready -> deaf
        bus_start();
        send_byte(ID_W, k0);
        bus_stop();
        chk("R9 no ack while not ready", k0, 0);
        chk("R9 no stop pulse while not ready", stop_cnt, 0);
        ready_i = 1'b1;
        wq();

        // vector table: single-byte writes (R2, R3, R7)
        for (int i = 0; i < N_VEC; i++) begin
            w0 = wr_cnt; s0 = stop_cnt;
            set_addr(WVEC[i][15:8], ka);
            send_byte(WVEC[i][7:0], k2);
            bus_stop();
            chk("R2 acks id/addr/data", {ka, k2}, 3'b111);
            chk("R3 one strobe", wr_cnt, w0 + 1);
            chk("R3 strobe address", last_wa, WVEC[i][15:8]);
            chk("R3 strobe data", last_wd, WVEC[i][7:0]);
            chk("R7 stop pulse", stop_cnt, s0 + 1);
        end

        // R3: burst write advances address
        w0 = wr_cnt;
        set_addr(8'h20, ka);
        send_byte(8'h11, k2);
        send_byte(8'h22, k3);
        bus_stop();
        chk("R3 burst acks", {ka, k2, k3}, 4'b1111);
        chk("R3 burst strobes", wr_cnt, w0 + 2);
        chk("R3 burst second address", last_wa, 8'h21);
        chk("R3 burst second data", last_wd, 8'h22);

        // R4: single read with repeated START
        r0 = rd_cnt;
        set_addr(WVEC[1][15:8], ka);
        bus_rstart();
        send_byte(ID_R, k2);
        recv_byte(1'b1, d);
        bus_stop();
        chk("R4 read acks", {ka, k2}, 3'b111);
        chk("R4 read data", d, WVEC[1][7:0]);
        chk("R4 one request", rd_cnt, r0 + 1);

        // R5: streaming read, then released after NACK
        r0 = rd_cnt;
        set_addr(8'h20, ka);
        bus_rstart();
        send_byte(ID_R, k2);
        recv_byte(1'b0, d); chk("R5 stream byte0", d, 8'h11);
        recv_byte(1'b0, d); chk("R5 stream byte1", d, 8'h22);
        recv_byte(1'b1, d); chk("R5 stream byte2", d, 8'h22 ^ 8'h3C);
        recv_byte(1'b1, d); chk("R5 released after nack", d, 8'hFF);
        bus_stop();
        chk("R5 request count", rd_cnt, r0 + 3);

        // R5: address wraps 255 -> 0
        set_addr(8'hFF, ka);
        bus_rstart();
        send_byte(ID_R, k2);
        recv_byte(1'b0, d); chk("R5 wrap byte at FF", d, 8'h5E);
        recv_byte(1'b1, d); chk("R5 wrap byte at 00", d, 8'h3C);
        bus_stop();

        // R1: wrong prefix, wrong strap
        w0 = wr_cnt;
        bus_start();
        send_byte(8'h5C, k0);
        send_byte(8'h30, k1);
        send_byte(8'h99, k2);
        bus_stop();
        chk("R1 wrong prefix nack", k0, 0);
        chk("R1 later bytes ignored", {k1, k2}, 2'b00);
        chk("R1 no strobe", wr_cnt, w0);
        bus_start();
        send_byte(8'h52, k0);
        bus_stop();
        chk("R1 wrong strap nack", k0, 0);

        // R6: busy blocks write
        w0 = wr_cnt;
        busy_i = 1'b1;
        set_addr(8'h40, ka);
        send_byte(8'h77, k2);
        send_byte(8'h78, k3);
        bus_stop();
        busy_i = 1'b0;
        chk("R6 id/addr acked", ka, 2'b11);
        chk("R6 busy data nack", {k2, k3}, 2'b00);
        chk("R6 no strobe", wr_cnt, w0);
        set_addr(8'h40, ka);
        bus_rstart();
        send_byte(ID_R, k2);
        recv_byte(1'b1, d);
        bus_stop();
        chk("R6 register unchanged", d, 8'h40 ^ 8'h3C);

        // R8: glitch filter on idle bus
        s0 = stop_cnt;
        g_sda = 1'b1; repeat (3) @(negedge clk); g_sda = 1'b0;
        wq(); wq();
        chk("R8 short sda pulse ignored", stop_cnt, s0);
        g_scl = 1'b1; repeat (3) @(negedge clk); g_scl = 1'b0;
        g_sda = 1'b1; repeat (8) @(negedge clk); g_sda = 1'b0;
        wq(); wq();
        chk("R8 long sda pulse seen as start/stop", stop_cnt, s0 + 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: run did not finish actual=hung expected=done");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

endmodule